// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Alarms

This block is the register-level core of a real-time clock. A 32-bit count of seconds moves forward by one on every pulse of an external one-second tick. Two 32-bit alarm compare registers are watched against the count. When the count reaches an alarm value, a sticky flag is set in a status word. Software clears each flag by writing a one to it. Each alarm also has a small configuration word. One bit lets the flag drive that alarm's interrupt line. Two more bits, set together, make the flag assert on every tick, which gives a once-per-second interrupt.

Software reaches the registers through a plain synchronous write port and a combinational read port. Registers sit on 32-bit word boundaries and are addressed by byte. A test byte comes out of reset non-zero. While it stays non-zero, the block reports that the clock has never been set up. Writing zero to that byte clears the report. A calibration word is kept as plain storage; it holds a value that other logic uses and has no effect inside this block.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the following read as zero: seconds count, both alarms, both configuration words, status and calibration. The test byte (offset 0x1C) reads 0xFF, clockUninit is 1 and both interrupt lines are 0.
- R2: Each cycle with tick high adds one to the seconds count (offset 0x0C), wrapping from 0xFFFFFFFF to 0. Without a tick the count holds.
- R3: A write to offset 0x0C loads the seconds count. A write in the same cycle as a tick wins and the tick is dropped.
- R4: Status bit 0 (alarm at 0x10) and status bit 1 (alarm at 0x14) set on the tick that makes the count equal to that alarm. Loading the count directly with the alarm value sets nothing.
- R5: Status (offset 0x00) is write-one-to-clear. Zero bits in the written word leave their flags unchanged. A flag set and a clear of that flag in the same cycle leave the flag set.
- R6: irqOut[i] is high while status bit i and bit 0 of that alarm's configuration word (0x04 for alarm 1, 0x08 for alarm 2) are both set. It stays high until either one is cleared.
- R7: When bit 1 (periodic enable) and bit 2 (one-per-second select) of a configuration word are both set, that alarm's status flag sets on every tick. Either bit alone sets nothing.
- R8: Configuration words read back bits 2:0 with the upper bits zero. The alarm words and the calibration word (0x18) read back all 32 bits. Writing calibration does not change counting. Writes whose address bits 1:0 are non-zero are ignored.
- R9: clockUninit is high exactly while bits 7:0 of the test word (offset 0x1C) are non-zero. Those bits read back as written, and bits above 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address for read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for regAddr (combinational) |
| irqOut | output | 2 | Per-alarm interrupt lines |
| clockUninit | output | 1 | Clock has not been set up (test byte non-zero) |

## Verification
Matching is swept over both alarms, with the alarm placed one to four ticks ahead of the count. This separates an off-by-one compare from a correct one, and shows that one alarm never sets the other's flag. All eight configuration-word values are applied to both alarms at once. This shows that only the periodic-plus-one-per-second pair makes a flag per tick, and that the enable bit alone gates the interrupt. Collisions in a single cycle are driven on purpose: a count write against a tick, and a flag set against its own clear. Wrap-around at the top of the count and misaligned writes are also covered.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int ADDR_W     = 5;
  localparam int IDX_W      = ADDR_W - 2;
  localparam int CFG_W      = 3;

  // word index = byte address / 4
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CFG0   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_TIME   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ALM0   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CALIB  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_TEST   = 3'd7;

  localparam int CFG_ALARM_EN = 0;
  localparam int CFG_PER_EN   = 1;
  localparam int CFG_ONE_HZ   = 2;

  typedef struct packed {
    logic                  tick;
    logic                  wrStatus;
    logic [NUM_ALARMS-1:0] wrCfg;
    logic                  wrTime;
    logic [NUM_ALARMS-1:0] wrAlarm;
    logic                  wrCalib;
    logic                  wrTest;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output rtcStrobes_t       strobes,
  output logic [IDX_W-1:0]  rdIdx
);
  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrOk;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign wrOk    = wrEn && aligned;
  assign rdIdx   = wordIdx;

  assign strobes.tick     = tick;
  assign strobes.wrStatus = wrOk && (wordIdx == IDX_STATUS);
  assign strobes.wrTime   = wrOk && (wordIdx == IDX_TIME);
  assign strobes.wrCalib  = wrOk && (wordIdx == IDX_CALIB);
  assign strobes.wrTest   = wrOk && (wordIdx == IDX_TEST);

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarmDec
    assign strobes.wrCfg[i]   = wrOk && (wordIdx == IDX_CFG0 + IDX_W'(i));
    assign strobes.wrAlarm[i] = wrOk && (wordIdx == IDX_ALM0 + IDX_W'(i));
  end
endmodule

// File: rtl/rtc_dpath.sv
`timescale 1ns/1ps
module rtc_dpath
  import rtc_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                TEST_W     = 8,
  parameter logic [TEST_W-1:0] TEST_RESET = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rtcStrobes_t           strobes,
  input  logic [IDX_W-1:0]      rdIdx,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_ALARMS-1:0] irqOut,
  output logic                  clockUninit,
  output logic [DATA_W-1:0]     timeVal,
  output logic [NUM_ALARMS-1:0] statusVal
);
  logic [DATA_W-1:0]                       timeQ;
  logic [DATA_W-1:0]                       timeNext;
  logic [NUM_ALARMS-1:0][DATA_W-1:0]       alarmQ;
  logic [NUM_ALARMS-1:0][CFG_W-1:0]        cfgQ;
  logic [NUM_ALARMS-1:0]                   statusQ;
  logic [NUM_ALARMS-1:0]                   setEv;
  logic [NUM_ALARMS-1:0]                   clrEv;
  logic [DATA_W-1:0]                       calibQ;
  logic [TEST_W-1:0]                       testQ;

  assign timeNext = timeQ + DATA_W'(1);

  always_comb begin
    for (int i = 0; i < NUM_ALARMS; i++) begin
      setEv[i] = strobes.tick &&
                 ((!strobes.wrTime && (timeNext == alarmQ[i])) ||
                  (cfgQ[i][CFG_PER_EN] && cfgQ[i][CFG_ONE_HZ]));
      clrEv[i] = strobes.wrStatus && wrData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ   <= '0;
      alarmQ  <= '0;
      cfgQ    <= '0;
      statusQ <= '0;
      calibQ  <= '0;
      testQ   <= TEST_RESET;
    end else begin
      if (strobes.wrTime)    timeQ <= wrData;
      else if (strobes.tick) timeQ <= timeNext;
      for (int i = 0; i < NUM_ALARMS; i++) begin
        if (strobes.wrAlarm[i]) alarmQ[i] <= wrData;
        if (strobes.wrCfg[i])   cfgQ[i]   <= wrData[CFG_W-1:0];
        if (setEv[i])           statusQ[i] <= 1'b1;
        else if (clrEv[i])      statusQ[i] <= 1'b0;
      end
      if (strobes.wrCalib) calibQ <= wrData;
      if (strobes.wrTest)  testQ  <= wrData[TEST_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_irq
    assign irqOut[i] = statusQ[i] && cfgQ[i][CFG_ALARM_EN];
  end

  assign clockUninit = |testQ;
  assign timeVal     = timeQ;
  assign statusVal   = statusQ;

  always_comb begin
    rdData = '0;
    case (rdIdx)
      IDX_STATUS:        rdData = DATA_W'(statusQ);
      IDX_CFG0:          rdData = DATA_W'(cfgQ[0]);
      IDX_CFG0 + 3'd1:   rdData = DATA_W'(cfgQ[1]);
      IDX_TIME:          rdData = timeQ;
      IDX_ALM0:          rdData = alarmQ[0];
      IDX_ALM0 + 3'd1:   rdData = alarmQ[1];
      IDX_CALIB:         rdData = calibQ;
      IDX_TEST:          rdData = DATA_W'(testQ);
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_seconds_core.sv
`timescale 1ns/1ps
module rtc_seconds_core
  import rtc_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                TEST_W     = 8,
  parameter logic [TEST_W-1:0] TEST_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [4:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        irqOut,
  output logic              clockUninit
);
  rtcStrobes_t           strobes;
  logic [IDX_W-1:0]      rdIdx;
  logic [DATA_W-1:0]     timeVal;
  logic [NUM_ALARMS-1:0] statusVal;

  rtc_ctrl ctrl_i (
    .tick(tick), .wrEn(wrEn), .regAddr(regAddr),
    .strobes(strobes), .rdIdx(rdIdx)
  );

  rtc_dpath #(.DATA_W(DATA_W), .TEST_W(TEST_W), .TEST_RESET(TEST_RESET)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdIdx(rdIdx),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .clockUninit(clockUninit), .timeVal(timeVal), .statusVal(statusVal)
  );
endmodule

// File: rtl/rtc_seconds_checker.sv
`timescale 1ns/1ps
module rtc_seconds_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [4:0]        regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        irqOut,
  input logic [DATA_W-1:0] timeVal,
  input logic [1:0]        statusVal,
  input logic              clockUninit
);
  logic timeWr, statusWr, testWr;
  assign timeWr   = wrEn && (regAddr == 5'h0C);
  assign statusWr = wrEn && (regAddr == 5'h00);
  assign testWr   = wrEn && (regAddr == 5'h1C);

  assert_time_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(tick) && !$past(timeWr) |-> timeVal == $past(timeVal) + DATA_W'(1));

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick) && !$past(timeWr) |-> $stable(timeVal));

  assert_time_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(timeWr) |-> timeVal == $past(wrData));

  assert_flag_needs_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVal[0]) |-> $past(tick));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusVal[1]) && !($past(statusWr) && $past(wrData[1])) |-> statusVal[1]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusWr) && $past(wrData[0]) && !$past(tick) |-> !statusVal[0]);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(irqOut[0]) && !$past(wrEn) |-> irqOut[0]);

  assert_test_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(testWr) && ($past(wrData[7:0]) == 8'h00) |-> !clockUninit);
endmodule

bind rtc_seconds_core rtc_seconds_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .regAddr(regAddr),
  .wrData(wrData), .irqOut(irqOut), .timeVal(timeVal),
  .statusVal(statusVal), .clockUninit(clockUninit)
);

// File: tb/rtc_seconds_core_tb.sv
`timescale 1ns/1ps
module rtc_seconds_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irqOut;
  logic        clockUninit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_seconds_core dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .clockUninit(clockUninit)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; wrEn = w; regAddr = a; wrData = d;
    @(posedge clk); #1;
    tick = 0; wrEn = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic tk(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 5'h00, 32'h0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    regAddr = a; #1; v = rdData;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      check("R1", $sformatf("reset read @%0h", i * 4), v, (i == 7) ? 32'hFF : 32'h0);
    end
    check("R1", "irq at reset", 32'(irqOut), 0);
    check("R1", "uninit at reset", 32'(clockUninit), 1);

    // R9 test byte
    wr(5'h1C, 32'h0);          check("R9", "uninit after zero", 32'(clockUninit), 0);
    wr(5'h1C, 32'h5A);         check("R9", "uninit after 5A", 32'(clockUninit), 1);
    rd(5'h1C, v);              check("R9", "test readback", v, 32'h5A);
    wr(5'h1C, 32'h100);        check("R9", "uninit upper only", 32'(clockUninit), 0);
    rd(5'h1C, v);              check("R9", "test upper reads zero", v, 32'h0);

    // R2 counting and wrap
    wr(5'h0C, 32'd100); tk(5);
    rd(5'h0C, v); check("R2", "five ticks", v, 32'd105);
    repeat (3) @(posedge clk); #1;
    rd(5'h0C, v); check("R2", "hold without tick", v, 32'd105);
    wr(5'h10, 32'h0000_2000); wr(5'h14, 32'h0000_3000);
    wr(5'h0C, 32'hFFFF_FFFE); tk(1);
    rd(5'h0C, v); check("R2", "to max", v, 32'hFFFF_FFFF);
    tk(1);
    rd(5'h0C, v); check("R2", "wrap to zero", v, 32'h0);

    // R3 write beats tick
    cyc(1'b1, 1'b1, 5'h0C, 32'd500);
    rd(5'h0C, v); check("R3", "write wins over tick", v, 32'd500);

    // R8 misaligned write ignored
    wr(5'h0D, 32'd7);
    rd(5'h0C, v); check("R8", "misaligned write ignored", v, 32'd500);

    // R4 sweep over both alarms and distances
    for (int i = 0; i < 2; i++) begin
      for (int k = 1; k <= 4; k++) begin
        base = 32'h1000 + 32'(i * 64 + k * 8);
        wr(5'(5'h10 + i * 4), base + 32'(k));
        wr(5'h0C, base);
        wr(5'h00, 32'h3);
        tk(k - 1);
        rd(5'h00, v); check("R4", $sformatf("no early flag a%0d k%0d", i, k), v, 0);
        tk(1);
        rd(5'h00, v); check("R4", $sformatf("flag on match a%0d k%0d", i, k), v, 32'(1 << i));
        wr(5'h00, 32'h3);
      end
    end
    wr(5'h10, 32'h2000); wr(5'h14, 32'h3000);
    wr(5'h0C, 32'h2000);
    rd(5'h00, v); check("R4", "direct load no flag", v, 0);
    tk(1);
    rd(5'h00, v); check("R4", "tick past alarm no flag", v, 0);

    // R5 write-one-to-clear
    wr(5'h0C, 32'h1FFF);
    cyc(1'b1, 1'b1, 5'h00, 32'h1);
    rd(5'h00, v); check("R5", "set beats clear", v, 32'h1);
    wr(5'h00, 32'h0);
    rd(5'h00, v); check("R5", "zero write no effect", v, 32'h1);
    wr(5'h00, 32'h2);
    rd(5'h00, v); check("R5", "other bit write keeps flag", v, 32'h1);
    wr(5'h00, 32'h1);
    rd(5'h00, v); check("R5", "one clears", v, 32'h0);

    // R6 interrupt gating
    wr(5'h04, 32'h1);
    wr(5'h0C, 32'h1FFF); tk(1);
    check("R6", "irq0 on match", 32'(irqOut), 32'h1);
    repeat (3) @(posedge clk); #1;
    check("R6", "irq0 held", 32'(irqOut), 32'h1);
    wr(5'h04, 32'h0);
    check("R6", "irq0 masked", 32'(irqOut), 32'h0);
    rd(5'h00, v); check("R6", "flag kept while masked", v, 32'h1);
    wr(5'h04, 32'h1);
    check("R6", "irq0 re-enabled", 32'(irqOut), 32'h1);
    wr(5'h00, 32'h1);
    check("R6", "irq0 cleared", 32'(irqOut), 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h1);
    wr(5'h0C, 32'h2FFF); tk(1);
    check("R6", "irq1 on match", 32'(irqOut), 32'h2);
    wr(5'h00, 32'h3);
    check("R6", "irq1 cleared", 32'(irqOut), 32'h0);

    // R7 periodic sweep over all configuration values
    wr(5'h0C, 32'd1000);
    for (int c = 0; c < 8; c++) begin
      logic per, en;
      per = c[1] && c[2];
      en  = c[0];
      wr(5'h04, 32'(c)); wr(5'h08, 32'(c));
      wr(5'h00, 32'h3);
      tk(1);
      rd(5'h00, v); check("R7", $sformatf("status cfg=%0d", c), v, per ? 32'h3 : 32'h0);
      check("R6", $sformatf("irq cfg=%0d", c), 32'(irqOut), (per && en) ? 32'h3 : 32'h0);
      rd(5'h04, v); check("R8", $sformatf("cfg readback %0d", c), v, 32'(c));
    end
    wr(5'h04, 32'h0); wr(5'h08, 32'h0); wr(5'h00, 32'h3);

    // R8 readback widths and calibration isolation
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); check("R8", "cfg upper bits zero", v, 32'h7);
    wr(5'h08, 32'h0);
    wr(5'h10, 32'hA5A5_5A5A);
    rd(5'h10, v); check("R8", "alarm1 readback", v, 32'hA5A5_5A5A);
    wr(5'h14, 32'h5A5A_A5A5);
    rd(5'h14, v); check("R8", "alarm2 readback", v, 32'h5A5A_A5A5);
    wr(5'h0C, 32'd50);
    wr(5'h18, 32'h1234_5678);
    tk(2);
    rd(5'h18, v); check("R8", "calib readback", v, 32'h1234_5678);
    rd(5'h0C, v); check("R8", "calib no effect on count", v, 32'd52);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule